// File: doc/BRIEF.md
# Dual-Channel Sampling ADC Readout Master

This block is the host-side master for a converter that samples two differential channels at the same instant and returns both results over a three-wire serial link. On a frame command it raises a convert strobe and runs a 34-period serial clock. It shifts in one two's-complement word per channel at fixed clock-edge positions and discards the padding and idle bit slots. It then sign-extends both words to 16 bits and presents them together with a one-cycle valid pulse. The converter always returns the samples taken at the previous convert edge. For this reason the first frame after reset, or after waking from sleep, is flagged as stale.

The same command port also drives the low-power sequences. Two convert pulses with the serial clock held low put the converter into nap. A longer train of convert pulses (four by default) puts it into sleep. A wake sequence pulses the serial clock with the convert strobe low. It then holds the block busy for a parameterised settling count before frames resume. Commands are taken only between sequences. The serial clock period is a parameter in system clocks, and the sample width is 12 or 14 bits.

Top module: `adc_frame_master`

## Requirements
- R1: After synchronous reset, `start_conv`, `ser_clk`, `word_valid`, `busy_o` and `stale_o` are low and `pwr_state` is 2'b00 (awake).
- R2: A frame command (cmd 2'b00) accepted at a clock edge raises `start_conv` at that edge for HALF_DIV cycles, with `ser_clk` low. `ser_clk` then gives 34 rising edges, each high and low phase being HALF_DIV cycles. `busy_o` falls 68*HALF_DIV cycles after acceptance. Both lines stay low while idle.
- R3: Data is taken from `ser_data` at each `ser_clk` rising edge, MSB first. Channel 0 uses rising edges 3 to 2+SAMPLE_W and channel 1 uses edges 19 to 18+SAMPLE_W. All other edges, including the two padding slots after each 12-bit word, are ignored.
- R4: Each word is sign-extended from SAMPLE_W bits to 16 bits on `ch0_word` / `ch1_word`.
- R5: `word_valid` is high for exactly one cycle, (35+2*SAMPLE_W)*HALF_DIV+1 cycles after frame acceptance. The words stay unchanged between valid pulses.
- R6: `stale_o`, updated with `word_valid`, is 1 for the first frame after reset and for the first frame after a wake sequence, and 0 otherwise.
- R7: `cmd_valid` is accepted only while `busy_o` is low. A command given while busy has no effect.
- R8: Nap (cmd 2'b01) gives NAP_PULSES convert pulses with `ser_clk` low, lasts 2*NAP_PULSES*HALF_DIV cycles, and leaves `pwr_state` = 2'b01.
- R9: Sleep (cmd 2'b10) gives SLEEP_PULSES convert pulses with `ser_clk` low and leaves `pwr_state` = 2'b10. While asleep, a frame command is refused: no convert pulse is issued and `busy_o` stays low.
- R10: Wake (cmd 2'b11) gives WAKE_PULSES serial clock pulses with `start_conv` low. It then stays busy for SETTLE_CYC cycles and ends with `pwr_state` = 2'b00, so the whole sequence lasts 2*WAKE_PULSES*HALF_DIV+SETTLE_CYC cycles.
- R11: A completed frame leaves `pwr_state` = 2'b00, including one issued from nap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | 00 frame, 01 nap, 10 sleep, 11 wake |
| ser_data | input | 1 | Serial data from converter |
| start_conv | output | 1 | Convert strobe |
| ser_clk | output | 1 | Serial clock |
| ch0_word | output | 16 | Channel 0 result, sign-extended |
| ch1_word | output | 16 | Channel 1 result, sign-extended |
| word_valid | output | 1 | One-cycle result strobe |
| stale_o | output | 1 | Result predates a reset or wake |
| busy_o | output | 1 | A sequence is running |
| pwr_state | output | 2 | 00 awake, 01 nap, 10 sleep |

## Verification
Every output is timed from the acceptance edge of a command. The convert strobe is high from that edge. The valid pulse comes (35+2*SAMPLE_W)*HALF_DIV+1 cycles later, and busy falls after 68*HALF_DIV cycles for a frame. For nap and sleep it falls after twice the pulse count times HALF_DIV, and for wake after 2*WAKE_PULSES*HALF_DIV+SETTLE_CYC. The bench counts falling clock edges from the edge that accepts the command. It records the exact count at which each event is seen and compares it with these formulas. Two widths run side by side, so the padding slots of the 12-bit word and the full 14-bit word are both exercised against a bench converter model that fills every unused slot with ones.

// File: rtl/adc_fm_pkg.sv
package adc_fm_pkg;
  typedef enum logic [1:0] {
    CMD_FRAME = 2'b00,
    CMD_NAP   = 2'b01,
    CMD_SLEEP = 2'b10,
    CMD_WAKE  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_AWAKE = 2'b00,
    PWR_NAP   = 2'b01,
    PWR_SLEEP = 2'b10
  } pwr_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FRAME, S_NAP, S_SLEEP, S_WAKE, S_SETTLE
  } seq_e;

  localparam int FRAME_EDGES = 34;
  localparam int CH0_FIRST   = 3;
  localparam int CH_STRIDE   = 16;
  localparam int NUM_CH      = 2;
  localparam int OUT_W       = 16;
  localparam int EKW         = 6;
endpackage

// File: rtl/adc_fm_tick.sv
module adc_fm_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV) + 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/adc_fm_seq.sv
module adc_fm_seq
  import adc_fm_pkg::*;
#(
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4,
  parameter int WAKE_PULSES  = 1,
  parameter int SETTLE_CYC   = 200000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd,
  input  logic           tick,
  output logic           run,
  output logic           conv,
  output logic           sck,
  output logic           rise,
  output logic [EKW-1:0] edge_k,
  output logic           wake_done,
  output pwr_e           pwr
);
  localparam int FR_H = 2 * FRAME_EDGES;
  localparam int NP_H = 2 * NAP_PULSES;
  localparam int SL_H = 2 * SLEEP_PULSES;
  localparam int WK_H = 2 * WAKE_PULSES;
  localparam int M1   = (FR_H > SL_H) ? FR_H : SL_H;
  localparam int M2   = (M1 > NP_H) ? M1 : NP_H;
  localparam int M3   = (M2 > WK_H) ? M2 : WK_H;
  localparam int HW   = $clog2(M3);
  localparam int SW   = $clog2(SETTLE_CYC + 1);
  localparam logic [HW-1:0] FR_LAST = HW'(FR_H - 1);
  localparam logic [HW-1:0] NP_LAST = HW'(NP_H - 1);
  localparam logic [HW-1:0] SL_LAST = HW'(SL_H - 1);
  localparam logic [HW-1:0] WK_LAST = HW'(WK_H - 1);
  localparam logic [SW-1:0] ST_LAST = SW'(SETTLE_CYC - 1);

  seq_e          st;
  logic [HW-1:0] h, h_inc;
  logic [SW-1:0] scnt;
  logic          accept;
  cmd_e          c;

  assign c      = cmd_e'(cmd);
  assign h_inc  = h + HW'(1);
  assign run    = (st != S_IDLE);
  assign accept = cmd_valid && (st == S_IDLE) &&
                  !((c == CMD_FRAME) && (pwr == PWR_SLEEP));
  assign rise   = (st == S_FRAME) && tick && !h[0];
  assign edge_k = EKW'({1'b0, h[HW-1:1]}) + EKW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      h         <= '0;
      scnt      <= '0;
      conv      <= 1'b0;
      sck       <= 1'b0;
      wake_done <= 1'b0;
      pwr       <= PWR_AWAKE;
    end else begin
      wake_done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          h    <= '0;
          scnt <= '0;
          case (c)
            CMD_FRAME: begin st <= S_FRAME; conv <= 1'b1; end
            CMD_NAP:   begin st <= S_NAP;   conv <= 1'b1; end
            CMD_SLEEP: begin st <= S_SLEEP; conv <= 1'b1; end
            default:   st <= S_WAKE;
          endcase
        end
        S_FRAME: if (tick) begin
          if (h == FR_LAST) begin
            st <= S_IDLE; sck <= 1'b0; conv <= 1'b0; pwr <= PWR_AWAKE;
          end else begin
            h <= h_inc; sck <= h_inc[0]; conv <= 1'b0;
          end
        end
        S_NAP: if (tick) begin
          if (h == NP_LAST) begin
            st <= S_IDLE; conv <= 1'b0; pwr <= PWR_NAP;
          end else begin
            h <= h_inc; conv <= ~h_inc[0];
          end
        end
        S_SLEEP: if (tick) begin
          if (h == SL_LAST) begin
            st <= S_IDLE; conv <= 1'b0; pwr <= PWR_SLEEP;
          end else begin
            h <= h_inc; conv <= ~h_inc[0];
          end
        end
        S_WAKE: if (tick) begin
          if (h == WK_LAST) begin
            st <= S_SETTLE; sck <= 1'b0;
          end else begin
            h <= h_inc; sck <= h_inc[0];
          end
        end
        S_SETTLE: begin
          if (scnt == ST_LAST) begin
            st <= S_IDLE; pwr <= PWR_AWAKE; wake_done <= 1'b1;
          end else begin
            scnt <= scnt + SW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_fm_capture.sv
module adc_fm_capture
  import adc_fm_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int FIRST_K  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise,
  input  logic [EKW-1:0]      edge_k,
  input  logic                din,
  output logic [SAMPLE_W-1:0] word
);
  localparam logic [EKW-1:0] LO = EKW'(FIRST_K);
  localparam logic [EKW-1:0] HI = EKW'(FIRST_K + SAMPLE_W - 1);

  logic in_slot;
  assign in_slot = (edge_k >= LO) && (edge_k <= HI);

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else if (rise && in_slot) word <= {word[SAMPLE_W-2:0], din};
  end
endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
  import adc_fm_pkg::*;
#(
  parameter int SAMPLE_W     = 14,
  parameter int HALF_DIV     = 4,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4,
  parameter int WAKE_PULSES  = 1,
  parameter int SETTLE_CYC   = 200000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd,
  input  logic        ser_data,
  output logic        start_conv,
  output logic        ser_clk,
  output logic [15:0] ch0_word,
  output logic [15:0] ch1_word,
  output logic        word_valid,
  output logic        stale_o,
  output logic        busy_o,
  output logic [1:0]  pwr_state
);
  localparam int XW = OUT_W - SAMPLE_W;
  localparam logic [EKW-1:0] LAST_K = EKW'(CH0_FIRST + CH_STRIDE + SAMPLE_W - 1);

  logic           run, tick, rise, wake_done, pend, stale_flag;
  logic [EKW-1:0] edge_k;
  pwr_e           pwr;
  logic [SAMPLE_W-1:0] cap [NUM_CH];

  adc_fm_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  adc_fm_seq #(
    .NAP_PULSES(NAP_PULSES), .SLEEP_PULSES(SLEEP_PULSES),
    .WAKE_PULSES(WAKE_PULSES), .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .tick(tick),
    .run(run), .conv(start_conv), .sck(ser_clk), .rise(rise),
    .edge_k(edge_k), .wake_done(wake_done), .pwr(pwr)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    adc_fm_capture #(
      .SAMPLE_W(SAMPLE_W), .FIRST_K(CH0_FIRST + ch * CH_STRIDE)
    ) u_cap (
      .clk(clk), .rst(rst), .rise(rise), .edge_k(edge_k),
      .din(ser_data), .word(cap[ch])
    );
  end

  assign busy_o    = run;
  assign pwr_state = pwr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      word_valid <= 1'b0;
      stale_o    <= 1'b0;
      stale_flag <= 1'b1;
      ch0_word   <= '0;
      ch1_word   <= '0;
    end else begin
      word_valid <= 1'b0;
      pend       <= rise && (edge_k == LAST_K);
      if (pend) begin
        word_valid <= 1'b1;
        ch0_word   <= {{XW{cap[0][SAMPLE_W-1]}}, cap[0]};
        ch1_word   <= {{XW{cap[1][SAMPLE_W-1]}}, cap[1]};
        stale_o    <= stale_flag;
        stale_flag <= 1'b0;
      end
      if (wake_done) stale_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_master_chk.sv
module adc_frame_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic        start_conv,
  input logic        ser_clk,
  input logic        word_valid,
  input logic        busy_o,
  input logic [1:0]  pwr_state,
  input logic [15:0] ch0_word,
  input logic [15:0] ch1_word
);
  assert_lines_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(start_conv && ser_clk));

  assert_idle_static_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!start_conv && !ser_clk));

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_valid_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> busy_o);

  assert_words_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> ($stable(ch0_word) && $stable(ch1_word)));

  assert_start_needs_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(cmd_valid));

  assert_sleep_no_conv_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b10) |-> !$rose(start_conv));
endmodule

bind adc_frame_master adc_frame_master_chk chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .start_conv(start_conv),
  .ser_clk(ser_clk), .word_valid(word_valid), .busy_o(busy_o),
  .pwr_state(pwr_state), .ch0_word(ch0_word), .ch1_word(ch1_word)
);

// File: tb/adc_frame_master_test.sv
module adc_conv_model #(
  parameter int W = 14
) (
  input  logic        conv,
  input  logic        sclk,
  input  logic [15:0] v0,
  input  logic [15:0] v1,
  output logic        sdo
);
  logic [W-1:0] held0 = '0, held1 = '0, out0 = '0, out1 = '0;
  int k = 0;

  function automatic logic bitf(int e, logic [W-1:0] a, logic [W-1:0] b);
    if (e >= 3 && e <= 2 + W) return a[W-1-(e-3)];
    if (e >= 19 && e <= 18 + W) return b[W-1-(e-19)];
    return 1'b1;
  endfunction

  initial sdo = 1'b1;

  always @(posedge conv or posedge sclk) begin
    if (conv) begin
      out0 = held0; out1 = held1;
      held0 = v0[W-1:0]; held1 = v1[W-1:0];
      k = 0;
    end else begin
      k = k + 1;
    end
    sdo = bitf(k + 1, out0, out1);
  end
endmodule

module adc_frame_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF   = 2;
  localparam int SETTLE = 50;
  localparam int WAKE   = 1;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic conv_a, sclk_a, sd_a, valid_a, stale_a, busy_a;
  logic conv_b, sclk_b, sd_b, valid_b, stale_b, busy_b;
  logic [15:0] w0a, w1a, w0b, w1b;
  logic [1:0] pwr_a, pwr_b;
  logic [15:0] v0a = 0, v1a = 0, v0b = 0, v1b = 0;
  logic [15:0] e0a = 0, e1a = 0, e0b = 0, e1b = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_master #(.SAMPLE_W(14), .HALF_DIV(HALF), .SETTLE_CYC(SETTLE),
                     .WAKE_PULSES(WAKE)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .ser_data(sd_a),
    .start_conv(conv_a), .ser_clk(sclk_a), .ch0_word(w0a), .ch1_word(w1a),
    .word_valid(valid_a), .stale_o(stale_a), .busy_o(busy_a), .pwr_state(pwr_a));

  adc_frame_master #(.SAMPLE_W(12), .HALF_DIV(HALF), .SETTLE_CYC(SETTLE),
                     .WAKE_PULSES(WAKE)) uut_w12 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .ser_data(sd_b),
    .start_conv(conv_b), .ser_clk(sclk_b), .ch0_word(w0b), .ch1_word(w1b),
    .word_valid(valid_b), .stale_o(stale_b), .busy_o(busy_b), .pwr_state(pwr_b));

  adc_conv_model #(.W(14)) mdl_a (.conv(conv_a), .sclk(sclk_a), .v0(v0a), .v1(v1a), .sdo(sd_a));
  adc_conv_model #(.W(12)) mdl_b (.conv(conv_b), .sclk(sclk_b), .v0(v0b), .v1(v1b), .sdo(sd_b));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(logic [1:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(conv_a == 0 && sclk_a == 0, "R1", "lines", {conv_a, sclk_a}, 0);
    chk(valid_a == 0 && stale_a == 0, "R1", "valid/stale", {valid_a, stale_a}, 0);
    chk(busy_a == 0, "R1", "busy", busy_a, 0);
    chk(pwr_a == 2'b00 && pwr_b == 2'b00, "R1", "pwr", pwr_a, 0);
  endtask

  task automatic t_frame(logic [15:0] n0a, n1a, n0b, n1b, bit ex_stale, bit inject);
    int n = 0, rises = 0, convhi = 0, va = -1, vb = -1, endn = -1;
    logic ps = 1'b0;
    logic [15:0] g0a = 0, g1a = 0, g0b = 0, g1b = 0;
    logic sa = 0, sb = 0;
    v0a = n0a; v1a = n1a; v0b = n0b; v1b = n1b;
    send(2'b00);
    chk(conv_a && !sclk_a, "R2", "conv at accept", conv_a, 1);
    while (n < 2000) begin
      if (conv_a) convhi++;
      if (sclk_a && !ps) rises++;
      ps = sclk_a;
      if (valid_a) begin va = n; g0a = w0a; g1a = w1a; sa = stale_a; end
      if (valid_b) begin vb = n; g0b = w0b; g1b = w1b; sb = stale_b; end
      if (!busy_a) begin endn = n; break; end
      if (inject && n == 10) begin cmd_valid = 1'b1; cmd = 2'b10; end
      else cmd_valid = 1'b0;
      @(negedge clk); n++;
    end
    cmd_valid = 1'b0;
    chk(convhi == HALF, "R2", "conv high cycles", convhi, HALF);
    chk(rises == 34, "R2", "sclk rises", rises, 34);
    chk(endn == 68 * HALF, "R2", "frame length", endn, 68 * HALF);
    chk(va == 63 * HALF + 1, "R5", "valid time w14", va, 63 * HALF + 1);
    chk(vb == 59 * HALF + 1, "R5", "valid time w12", vb, 59 * HALF + 1);
    chk(g0a == e0a && g1a == e1a, "R3", "w14 words ch0", g0a, e0a);
    chk(g1a == e1a, "R4", "w14 word ch1", g1a, e1a);
    chk(g0b == e0b, "R3", "w12 word ch0 padding", g0b, e0b);
    chk(g1b == e1b, "R4", "w12 word ch1", g1b, e1b);
    chk(sa == ex_stale && sb == ex_stale, "R6", "stale", sa, ex_stale);
    chk(pwr_a == 2'b00, "R11", "pwr after frame", pwr_a, 0);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(busy_a == 0 && pwr_a == 2'b00, "R7", "cmd while busy ignored", {busy_a, pwr_a}, 0);
    end
    e0a = n0a; e1a = n1a; e0b = n0b; e1b = n1b;
  endtask

  task automatic t_mode(logic [1:0] c, int econv, int esck, int elen, int epwr, string req);
    int n = 0, cr = 0, sr = 0, endn = -1;
    logic pc = 1'b0, ps = 1'b0;
    send(c);
    while (n < 2000) begin
      if (conv_a && !pc) cr++;
      if (sclk_a && !ps) sr++;
      pc = conv_a; ps = sclk_a;
      if (!busy_a) begin endn = n; break; end
      @(negedge clk); n++;
    end
    chk(cr == econv, req, "convert pulses", cr, econv);
    chk(sr == esck, req, "serial clock pulses", sr, esck);
    chk(endn == elen, req, "sequence length", endn, elen);
    chk(pwr_a == epwr[1:0] && pwr_b == epwr[1:0], req, "power state", pwr_a, epwr);
  endtask

  task automatic t_sleep_refuse();
    int cr = 0, bz = 0;
    send(2'b00);
    for (int i = 0; i < 6; i++) begin
      if (conv_a) cr++;
      if (busy_a) bz++;
      @(negedge clk);
    end
    chk(cr == 0 && bz == 0, "R9", "frame refused in sleep", cr + bz, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_frame(16'h1234, 16'hF00D, 16'h0123, 16'hFABC, 1'b1, 1'b0);
    t_frame(16'h1FFF, 16'hE000, 16'h07FF, 16'hF800, 1'b0, 1'b0);
    t_frame(16'hFFFF, 16'h0001, 16'hFFFF, 16'h0555, 1'b0, 1'b0);
    t_frame(16'h1555, 16'hEAAA, 16'h02AA, 16'hFD55, 1'b0, 1'b1);
    t_frame(16'h0000, 16'h0F0F, 16'h0000, 16'h00F0, 1'b0, 1'b0);
    t_mode(2'b01, 2, 0, 4 * HALF, 1, "R8");
    t_frame(16'h0ABC, 16'hF543, 16'h0321, 16'hFCDE, 1'b0, 1'b0);
    t_mode(2'b10, 4, 0, 8 * HALF, 2, "R9");
    t_sleep_refuse();
    t_mode(2'b11, 0, WAKE, 2 * WAKE * HALF + SETTLE, 0, "R10");
    t_frame(16'h0011, 16'hFFEE, 16'h0022, 16'hFFDD, 1'b1, 1'b0);
    t_frame(16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule